// File: doc/BRIEF.md
# Firmware Hub Read Host Engine

This block is the host side of a 4-bit multiplexed firmware-hub bus, limited to single-byte reads. A user request supplies a 4-bit device select and a 28-bit byte address. The engine then runs one complete bus cycle. It opens with a one-clock frame strobe and a start code. It sends the select nibble, the address as seven nibbles and a size nibble, and drives one turnaround nibble before it releases the bus.

The addressed device answers with any number of wait nibbles and then a ready nibble. The data byte follows as two nibbles, low nibble first, and the cycle closes with two turnaround clocks during which the device owns the bus. At the end the engine pulses `done` and presents the byte on `rd_data`.

If no ready nibble arrives within `SYNC_LIMIT` sync clocks, the engine aborts. It pulls the frame strobe low for `ABORT_CLKS` clocks with 1111b on the bus and then pulses `err`. The bus pad is split into three signals: `bus_out`, `bus_oe` and `bus_in`.

Top module: `fwh_read_host`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `err` and `bus_oe` are 0 and `frame_n` is 1.
- R2: A request is accepted only on a clock edge at which `req_valid` is 1 and `busy` is 0. While `busy` is 1, `req_valid` and the request fields are ignored: the running cycle and its result are unchanged, and no new cycle starts afterwards.
- R3: In the first clock after acceptance, `frame_n` is 0, `bus_oe` is 1 and `bus_out` is the start code 1101b. `frame_n` is 1 in every other clock of a normal read.
- R4: The next clock drives the select nibble. The seven clocks after it drive the address, bits [27:24] first and bits [3:0] last, each with `bus_oe` 1.
- R5: After the address, the engine drives the size nibble 0000b for one clock and then 1111b for one clock, both with `bus_oe` 1. In the following clock `bus_oe` is 0.
- R6: Once `bus_oe` has dropped within a cycle, it stays 0 until the cycle ends, unless an abort starts.
- R7: From the third clock after the 1111b turnaround, the engine samples `bus_in` every clock. Any value other than 0000b is a wait, and the first 0000b ends the sync phase. The next two clocks carry the data low nibble and then the high nibble.
- R8: Two clocks after the high data nibble, `done` is 1 for exactly one clock. In that clock `busy` is 0 and `rd_data` holds {high nibble, low nibble}.
- R9: A ready nibble in sync clock number `SYNC_LIMIT` (counting from 1) still completes the read. If all `SYNC_LIMIT` sync clocks show a wait, the engine aborts.
- R10: An abort drives `frame_n` 0, `bus_oe` 1 and `bus_out` 1111b for `ABORT_CLKS` clocks. In the next clock `err` is 1 for one clock, `busy` is 0 and `done` stays 0.
- R11: `busy` is 1 from the clock after acceptance until the clock in which `done` or `err` is raised, and it is 0 in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_sel | input | 4 | Device select for the request |
| req_addr | input | 28 | Byte address for the request |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse: read completed |
| err | output | 1 | One-clock pulse: read aborted on timeout |
| rd_data | output | 8 | Byte returned by the last completed read |
| frame_n | output | 1 | Active-low frame strobe |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| bus_in | input | 4 | Nibble read from the bus |

## Verification
All outputs come from registered state, so every result can be predicted by counting clocks from the accepting edge. With W wait nibbles, sample k after acceptance shows the start code at k=1, the select nibble at k=2, the address at k=3..9, the size nibble at k=10, and the turnaround at k=11 with the output enable on. The enable is off from k=12. `done` is due at k=18+W, and on timeout `err` is due at k=17+SYNC_LIMIT after four abort clocks.

The bench samples every output on the falling edge, using the same k index for each check. As the device it drives `bus_in` on that falling edge, so each value is settled before the rising edge that samples it. Random selects, addresses, data and wait counts are mixed with directed cases: zero waits, the two-wait timing, a ready nibble in the last allowed sync clock, a full timeout, and a request held active throughout a busy cycle.

// File: rtl/fwh_read_host.sv
module fwh_read_host #(
  parameter int SYNC_LIMIT = 32,
  parameter int ABORT_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [3:0]  req_sel,
  input  logic [27:0] req_addr,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [7:0]  rd_data,
  output logic        frame_n,
  output logic [3:0]  bus_out,
  output logic        bus_oe,
  input  logic [3:0]  bus_in
);

  localparam logic [3:0] START_CODE = 4'b1101;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] TURN_NIB   = 4'b1111;
  localparam logic [3:0] SIZE_ONE   = 4'b0000;
  localparam int ADDR_NIBS = 7;
  localparam int CNT_MAX   = (SYNC_LIMIT > ABORT_CLKS) ? SYNC_LIMIT : ABORT_CLKS;
  localparam int CW        = ($clog2(CNT_MAX) > 3) ? $clog2(CNT_MAX) : 3;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SEL, S_ADDR, S_SIZE, S_TURN0, S_TURN1,
    S_SYNC, S_DLO, S_DHI, S_TURN2, S_TURN3, S_ABORT
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [3:0]    sel_q;
  logic [27:0]   addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sel_q   <= '0;
      addr_q  <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            sel_q  <= req_sel;
            addr_q <= req_addr;
            st     <= S_START;
          end
        S_START: st <= S_SEL;
        S_SEL: begin
          st  <= S_ADDR;
          cnt <= '0;
        end
        S_ADDR: begin
          addr_q <= {addr_q[23:0], 4'h0};
          if (cnt == CW'(ADDR_NIBS - 1)) begin
            st  <= S_SIZE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SIZE:  st <= S_TURN0;
        S_TURN0: st <= S_TURN1;
        S_TURN1: begin
          st  <= S_SYNC;
          cnt <= '0;
        end
        S_SYNC:
          if (bus_in == SYNC_READY) begin
            st <= S_DLO;
          end else if (cnt == CW'(SYNC_LIMIT - 1)) begin
            st  <= S_ABORT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_DLO: begin
          rd_data[3:0] <= bus_in;
          st <= S_DHI;
        end
        S_DHI: begin
          rd_data[7:4] <= bus_in;
          st <= S_TURN2;
        end
        S_TURN2: st <= S_TURN3;
        S_TURN3: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        S_ABORT:
          if (cnt == CW'(ABORT_CLKS - 1)) begin
            st  <= S_IDLE;
            err <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign frame_n = !(st == S_START || st == S_ABORT);
  assign bus_oe  = st inside {S_START, S_SEL, S_ADDR, S_SIZE, S_TURN0, S_ABORT};

  always_comb begin
    case (st)
      S_START: bus_out = START_CODE;
      S_SEL:   bus_out = sel_q;
      S_ADDR:  bus_out = addr_q[27:24];
      S_SIZE:  bus_out = SIZE_ONE;
      default: bus_out = TURN_NIB;
    endcase
  end

  // R3
  start_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!frame_n && bus_oe && bus_out == START_CODE));

  // R10
  frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (bus_oe && (bus_out == START_CODE || bus_out == TURN_NIB)));

  // R11
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_oe) |=> (!bus_oe || !frame_n || !busy));

  // R10
  err_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(!frame_n));

endmodule

// File: tb/sim_fwh_read_host.sv
`timescale 1ns/1ps
module sim_fwh_read_host;
  localparam int T  = 32;
  localparam int AB = 4;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] req_sel = '0, bus_in = 4'hF;
  logic [27:0] req_addr = '0;
  logic busy, done, err, frame_n, bus_oe;
  logic [7:0] rd_data;
  logic [3:0] bus_out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  fwh_read_host #(.SYNC_LIMIT(T), .ABORT_CLKS(AB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_addr(req_addr), .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .frame_n(frame_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in));

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", rq, got, exp, $time);
    end
  endtask

  // expected {frame_n, bus_oe, busy, done, err} for sample k
  function automatic logic [4:0] exp_ctl(input int k, input int w, input bit tmo);
    int fin;
    fin = tmo ? 17 + T : 18 + w;
    if (k == 1) return 5'b01100;
    if (k <= 11) return 5'b11100;
    if (k == fin) return tmo ? 5'b10001 : 5'b10010;
    if (k > fin) return 5'b10000;
    if (tmo && k >= 13 + T) return 5'b01100;
    return 5'b10100;
  endfunction

  function automatic logic [3:0] exp_nib(input int k, input logic [3:0] s, input logic [27:0] a);
    if (k == 1) return 4'b1101;
    if (k == 2) return s;
    if (k <= 9) return a[27 - 4*(k-3) -: 4];
    if (k == 10) return 4'b0000;
    return 4'b1111;
  endfunction

  function automatic logic [3:0] wait_nib(input int i);
    logic [3:0] v;
    if (i % 3 != 2) return 4'b0101;
    v = 4'($urandom_range(1, 15));
    return v;
  endfunction

  task automatic run_read(input logic [3:0] s, input logic [27:0] a, input int w,
                          input logic [7:0] d, input bit hold);
    bit tmo;
    int fin;
    logic [4:0] ctl;
    logic [3:0] en;
    tmo = (w >= T);
    fin = tmo ? 17 + T : 18 + w;
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_addr = a;
    for (int k = 1; k <= fin + 1; k++) begin
      @(negedge clk);
      if (hold && k < fin - 1) begin
        req_sel = ~s; req_addr = ~a; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      ctl = exp_ctl(k, w, tmo);
      if (k == 1) chk("R3 start/R11 busy", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      else if (k <= 11) chk("R4/R5 header ctl", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      else if (k == 12) chk("R5 oe release", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      else if (tmo && k >= 13 + T && k < fin) chk("R10 abort ctl", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      else if (k == fin) chk(tmo ? "R10 err pulse" : "R8 done pulse", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      else if (k > fin) chk(hold ? "R2 no restart" : "R8 pulse end", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      else chk("R6 oe off", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, ctl});
      if (bus_oe === 1'b1 && ((k <= 11) || (tmo && k >= 13 + T && k < fin))) begin
        en = exp_nib(k, s, a);
        chk(k <= 2 ? "R3/R4 nibble" : (k <= 9 ? "R4 address" : (k <= 11 ? "R5 size/turn" : "R10 abort nibble")),
            {28'd0, bus_out}, {28'd0, en});
      end
      if (!tmo && k == fin) chk("R7/R8 rd_data", {24'd0, rd_data}, {24'd0, d});
      if (k >= 13 && k <= 12 + w) bus_in = wait_nib(k);
      else if (!tmo && k == 13 + w) bus_in = 4'b0000;
      else if (!tmo && k == 14 + w) bus_in = d[3:0];
      else if (!tmo && k == 15 + w) bus_in = d[7:4];
      else if (!tmo && k == 16 + w) bus_in = 4'b1111;
      else bus_in = 4'($urandom);
    end
    bus_in = 4'hF;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, 5'b10000});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {27'd0, frame_n, bus_oe, busy, done, err}, {27'd0, 5'b10000});
    run_read(4'h0, 28'h0000000, 0, 8'hA5, 1'b0);
    run_read(4'h3, 28'hFEDCBA9, 2, 8'h3C, 1'b0);
    run_read(4'hF, 28'h1234567, T - 1, 8'h81, 1'b0);     // R9 last allowed sync clock
    run_read(4'h5, 28'h0ABCDEF, T, 8'h00, 1'b0);         // R9 timeout
    run_read(4'h9, 28'h5A5A5A5, T + 3, 8'h00, 1'b0);     // R10 device never ready
    run_read(4'h6, 28'h7654321, 3, 8'hE7, 1'b1);         // R2 request held while busy
    for (int i = 0; i < 30; i++)
      run_read(4'($urandom), 28'($urandom), int'($urandom_range(0, 10)), 8'($urandom), i % 5 == 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule